// File: doc/BRIEF.md
# Boot-Overlay Address Decoder with Interleaved ROM and Byte RAM

This block sits between a 24-bit-address processor bus and the system's first memories. Each access is sent to a boot ROM, to a byte-addressed main RAM, or to a single control bit. After reset the control bit is clear and the block runs in an overlay mode: address bit 23 is forced high on every access. The processor therefore fetches its reset vectors and boot code from ROM, even at address zero. Boot code then writes the control register. The low half of the map then reaches RAM, and ROM is still reachable at its own window.

The ROM is built from two byte-wide devices. One supplies the even byte offsets and the other the odd offsets. The image repeats throughout its 4 MB window. Byte, word and long accesses are put together in big-endian order. Reads are answered within the same cycle and writes take effect on the clock edge. Writes that land in ROM are dropped. A read that selects nothing returns all ones at the access width. A dedicated port loads the two ROM byte streams.

The map control is a two-state machine. In state `MAP_BOOT`, entered on reset, the overlay is active. In state `MAP_NORMAL` the overlay is released. The transition `LEAVE_BOOT` fires on a control write whose selected data bit is 1. The transition `REENTER_BOOT` fires on a control write whose selected data bit is 0. Any other write to the control register leaves the state as it is.

Top module: `boot_map_decoder`

## Requirements
- R1: In state `MAP_BOOT`, bit 23 of every address is forced to 1 before decoding, for both reads and writes. Address 0x000000 therefore reads ROM, and a write there does not change RAM.
- R2: Reset (active-low `rst_n`) puts the map control in `MAP_BOOT`.
- R3: Decoded addresses 0x800000 to 0xBFFFFF select ROM. Each byte of an access reads ROM index (address + lane) modulo `ROM_BYTES`, so the image repeats through the window and a multi-byte access wraps inside it.
- R4: A ROM byte at an even index comes from the even device and a byte at an odd index comes from the odd device. Loader entry j holds index 2j (even stream) and index 2j+1 (odd stream).
- R5: A write that decodes to the ROM window changes neither ROM nor RAM.
- R6: An access selects RAM when every byte it covers lies below `RAM_BYTES`. `RAM_BYTES` = `RAM_UNIT_BYTES` × `RAM_UNITS`, with `RAM_UNITS` one of 1, 2, 3, 4, 5, 6 or 8 (a 512 KB unit in the full system).
- R7: The size codes are 00 = byte, 01 = word, 10 = long, and 11 behaves as long. Accesses are big-endian: the lowest address holds the most significant byte. Read data is right-aligned with the upper bits zero. Write data is taken from the low 1, 2 or 4 bytes of `bus_wdata`.
- R8: A read that selects nothing returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, word or long. This includes RAM accesses that run past the end of RAM and reads of the write-only control address. A write that selects nothing has no effect.
- R9: A write to decoded address 0xE43000 loads the map bit. A byte write loads `bus_wdata[7]`; a word or long write loads `bus_wdata[15]`. A 1 moves to `MAP_NORMAL` and a 0 moves to `MAP_BOOT`.
- R10: The control register can be written while the overlay is active, at 0xE43000 or at any address that becomes 0xE43000 once bit 23 is forced (for example 0x643000).
- R11: Read data follows the address in the same cycle. Writes and ROM loader entries take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the map control |
| init_we | input | 1 | ROM loader write strobe |
| init_pair | input | ROM_PAIR_W | ROM loader pair index (byte index / 2) |
| init_even | input | 8 | Byte for the even ROM device |
| init_odd | input | 8 | Byte for the odd ROM device |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code (R7) |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |

## Verification
The hardest case to reach from the ports is a write issued in `MAP_BOOT` that would have hit RAM without the overlay. RAM is only visible once the overlay is released, so the stimulus seeds a RAM location in `MAP_NORMAL` and then returns to `MAP_BOOT` with a control write. It writes the same low address, releases the overlay again and reads the location to confirm it is unchanged. This round trip is repeated with byte, word and long control writes, and once through the aliased control address 0x643000. The same cycles also check which data bit each size samples. Exhaustive sweeps of every ROM and RAM offset at all three sizes cover the wrap and straddle boundaries.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_ROM,
        RGN_RAM,
        RGN_CTRL
    } region_e;

    typedef enum logic {
        MAP_BOOT   = 1'b0,
        MAP_NORMAL = 1'b1
    } map_state_e;

    localparam logic [23:0] OVERLAY_MASK = 24'h80_0000;
    localparam logic [23:0] ROM_FIRST    = 24'h80_0000;
    localparam logic [23:0] ROM_LAST     = 24'hBF_FFFF;
    localparam logic [23:0] CTRL_ADDR    = 24'hE4_3000;
    localparam int          LANES        = 4;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_WORD: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
    import boot_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic overlay_on
);

    map_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_BOOT;
        else        state_q <= state_d;
    end

    // LEAVE_BOOT / REENTER_BOOT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_BOOT:   if (ctrl_wr && ctrl_bit)  state_d = MAP_NORMAL;
            MAP_NORMAL: if (ctrl_wr && !ctrl_bit) state_d = MAP_BOOT;
        endcase
    end

    always_comb begin
        overlay_on = (state_q == MAP_BOOT);
    end

    a_r2_boot_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_q == MAP_BOOT);

    a_r9_ctrl_loads_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> state_q == map_state_e'($past(ctrl_bit)));

    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(state_q));

endmodule

// File: rtl/boot_map_rom.sv
module boot_map_rom
    import boot_map_pkg::*;
#(
    parameter int ROM_BYTES = 64,
    localparam int ROM_AW   = $clog2(ROM_BYTES),
    localparam int PAIRS    = ROM_BYTES / 2,
    localparam int PAIR_W   = ROM_AW - 1
) (
    input  logic                        clk,
    input  logic                        init_we,
    input  logic [PAIR_W-1:0]           init_pair,
    input  logic [7:0]                  init_even,
    input  logic [7:0]                  init_odd,
    input  logic [LANES-1:0][ROM_AW-1:0] rd_idx,
    output logic [LANES-1:0][7:0]        rd_byte
);

    logic [7:0] even_q [PAIRS];
    logic [7:0] odd_q  [PAIRS];

    always_ff @(posedge clk) begin
        if (init_we) begin
            even_q[init_pair] <= init_even;
            odd_q[init_pair]  <= init_odd;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd_byte[k] = rd_idx[k][0] ? odd_q[rd_idx[k][ROM_AW-1:1]]
                                         : even_q[rd_idx[k][ROM_AW-1:1]];
    end

endmodule

// File: rtl/boot_map_ram.sv
module boot_map_ram
    import boot_map_pkg::*;
#(
    parameter int RAM_BYTES = 256,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             we,
    input  logic [LANES-1:0][RAM_AW-1:0] idx,
    input  logic [LANES-1:0][7:0]        wd,
    output logic [LANES-1:0][7:0]        rd
);

    logic [7:0] mem_q [RAM_BYTES];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (we[k]) mem_q[idx[k]] <= wd[k];
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rd[k] = mem_q[idx[k]];

        a_r6_lane_in_ram: assert property (@(posedge clk) disable iff (!rst_n)
            we[k] |-> int'(idx[k]) < RAM_BYTES);
    end

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
    import boot_map_pkg::*;
#(
    parameter int ROM_BYTES      = 64,
    parameter int RAM_UNIT_BYTES = 128,
    parameter int RAM_UNITS      = 2,
    localparam int RAM_BYTES     = RAM_UNIT_BYTES * RAM_UNITS,
    localparam int ROM_AW        = $clog2(ROM_BYTES),
    localparam int RAM_AW        = $clog2(RAM_BYTES),
    localparam int ROM_PAIR_W    = ROM_AW - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_we,
    input  logic [ROM_PAIR_W-1:0] init_pair,
    input  logic [7:0]            init_even,
    input  logic [7:0]            init_odd,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [1:0]            bus_size,
    input  logic [23:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata
);

    logic                          overlay_on;
    logic [23:0]                   eff_addr;
    logic [2:0]                    nbytes;
    logic [24:0]                   end_addr;
    region_e                       region;
    logic                          ctrl_wr, ctrl_bit;
    logic [LANES-1:0][ROM_AW-1:0]  rom_idx;
    logic [LANES-1:0][RAM_AW-1:0]  ram_idx;
    logic [LANES-1:0][7:0]         rom_b, ram_b, lane_rd, lane_wd;
    logic [LANES-1:0]              ram_we;

    boot_map_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_bit   (ctrl_bit),
        .overlay_on (overlay_on)
    );

    always_comb begin
        eff_addr = overlay_on ? (bus_addr | OVERLAY_MASK) : bus_addr;
        nbytes   = size_bytes(bus_size);
        end_addr = {1'b0, eff_addr} + 25'(nbytes);
        if (eff_addr >= ROM_FIRST && eff_addr <= ROM_LAST)
            region = RGN_ROM;
        else if (end_addr <= 25'(RAM_BYTES))
            region = RGN_RAM;
        else if (eff_addr == CTRL_ADDR)
            region = RGN_CTRL;
        else
            region = RGN_NONE;
    end

    always_comb begin
        ctrl_wr  = bus_valid && bus_write && (region == RGN_CTRL);
        ctrl_bit = (bus_size == SZ_BYTE) ? bus_wdata[7] : bus_wdata[15];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rom_idx[k] = ROM_AW'(eff_addr + 24'(k));
        assign ram_idx[k] = RAM_AW'(eff_addr + 24'(k));
        assign ram_we[k]  = bus_valid && bus_write && (region == RGN_RAM)
                            && (k < int'(nbytes));
        assign lane_rd[k] = (region == RGN_ROM) ? rom_b[k] :
                            (region == RGN_RAM) ? ram_b[k] : 8'hFF;
        assign lane_wd[k] = (k < int'(nbytes))
                            ? bus_wdata[8*(int'(nbytes)-1-k) +: 8] : 8'h00;
    end

    boot_map_rom #(.ROM_BYTES(ROM_BYTES)) u_rom (
        .clk       (clk),
        .init_we   (init_we),
        .init_pair (init_pair),
        .init_even (init_even),
        .init_odd  (init_odd),
        .rd_idx    (rom_idx),
        .rd_byte   (rom_b)
    );

    boot_map_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .idx   (ram_idx),
        .wd    (lane_wd),
        .rd    (ram_b)
    );

    always_comb begin
        unique case (bus_size)
            SZ_BYTE: bus_rdata = {24'h0, lane_rd[0]};
            SZ_WORD: bus_rdata = {16'h0, lane_rd[0], lane_rd[1]};
            default: bus_rdata = {lane_rd[0], lane_rd[1], lane_rd[2], lane_rd[3]};
        endcase
    end

    a_r1_overlay_hides_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (overlay_on && bus_valid) |-> region != RGN_RAM);

    a_r5_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && region == RGN_ROM) |-> ram_we == '0);

    a_r8_miss_long_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && region == RGN_NONE && bus_size == SZ_LONG)
        |-> bus_rdata == 32'hFFFF_FFFF);

    a_r9_ctrl_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> ram_we == '0);

endmodule

// File: tb/boot_map_decoder_tb.sv
module boot_map_decoder_tb;

    localparam int ROMB = 64;
    localparam int RAMB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_we = 1'b0;
    logic [4:0]  init_pair = '0;
    logic [7:0]  init_even = '0, init_odd = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b00;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0, errors = 0;
    logic [7:0] exp_ram [RAMB];

    always #5 clk = ~clk;

    boot_map_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_pair(init_pair),
        .init_even(init_even), .init_odd(init_odd), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] rom_byte(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic int nb_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ones(input logic [1:0] sz);
        return (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] rom_exp(input int a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int k = 0; k < nb_of(sz); k++) v = (v << 8) | 32'(rom_byte((a + k) % ROMB));
        return v;
    endfunction

    function automatic logic [31:0] ram_exp(input int a, input logic [1:0] sz);
        logic [31:0] v = '0;
        if (a + nb_of(sz) > RAMB) return ones(sz);
        for (int k = 0; k < nb_of(sz); k++) v = (v << 8) | 32'(exp_ram[a + k]);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [23:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        #1 bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [23:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [23:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
        logic [31:0] d;
        rd(a, sz, d);
        chk(req, d, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : stim
        // R11 R4: loader entries during reset
        for (int j = 0; j < ROMB / 2; j++) begin
            @(negedge clk);
            init_we = 1'b1; init_pair = 5'(j);
            init_even = rom_byte(2 * j); init_odd = rom_byte(2 * j + 1);
        end
        @(negedge clk); init_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2 R1: after reset address 0 reads ROM
        rchk("R2 reset overlay", 24'h0, 2'b00, 32'(rom_byte(0)));

        // R1 R3 R4 R7: overlay sweep of all offsets, low and mirrored addresses
        for (int a = 0; a < ROMB; a++) begin
            for (int s = 0; s < 3; s++) begin
                rchk("R1 R4 overlay rom", 24'(a), 2'(s), rom_exp(a, 2'(s)));
                rchk("R3 mirror rom", 24'(24'h3FF000 + a), 2'(s), rom_exp(a, 2'(s)));
            end
        end
        rchk("R7 rsvd size as long", 24'h3E, 2'b11, rom_exp(62, 2'b10));

        // R5: write to ROM in overlay ignored
        wr(24'h4, 2'b10, 32'hDEAD_BEEF);
        rchk("R5 rom write ignored", 24'h4, 2'b10, rom_exp(4, 2'b10));

        // R9 R10: byte write bit7 at control releases overlay
        wr(24'hE43000, 2'b00, 32'h80);
        for (int a = 0; a < RAMB; a++) begin
            exp_ram[a] = 8'((a * 13 + 8'h5A) & 255);
            wr(24'(a), 2'b00, 32'(exp_ram[a]));
        end
        // R6 R7 R8: RAM sweep
        for (int a = 0; a < RAMB; a++) begin
            for (int s = 0; s < 3; s++)
                rchk("R6 R7 R8 ram sweep", 24'(a), 2'(s), ram_exp(a, 2'(s)));
        end

        // R7: big-endian writes
        wr(24'h20, 2'b10, 32'h1122_3344);
        exp_ram[8'h20] = 8'h11; exp_ram[8'h21] = 8'h22; exp_ram[8'h22] = 8'h33; exp_ram[8'h23] = 8'h44;
        rchk("R7 long write byte0", 24'h20, 2'b00, 32'h11);
        rchk("R7 long write byte3", 24'h23, 2'b00, 32'h44);
        wr(24'h40, 2'b01, 32'hFFFF_A1B2);
        exp_ram[8'h40] = 8'hA1; exp_ram[8'h41] = 8'hB2;
        rchk("R7 word write", 24'h3F, 2'b10, ram_exp(8'h3F, 2'b10));
        wr(24'h50, 2'b00, 32'h1234_56C3);
        exp_ram[8'h50] = 8'hC3;
        rchk("R7 byte write", 24'h4F, 2'b10, ram_exp(8'h4F, 2'b10));

        // R8: misses
        rchk("R8 miss byte", 24'h100, 2'b00, 32'hFF);
        rchk("R8 miss word", 24'h100, 2'b01, 32'hFFFF);
        rchk("R8 straddle word", 24'hFF, 2'b01, 32'hFFFF);
        rchk("R8 straddle long", 24'hFD, 2'b10, 32'hFFFF_FFFF);
        wr(24'hFD, 2'b10, 32'h0);
        rchk("R8 straddle write dropped", 24'hFD, 2'b00, 32'(exp_ram[8'hFD]));
        rchk("R8 straddle write dropped", 24'hFF, 2'b00, 32'(exp_ram[8'hFF]));
        rchk("R8 ctrl read ones", 24'hE43000, 2'b10, 32'hFFFF_FFFF);
        rchk("R8 above rom window", 24'hC00000, 2'b00, 32'hFF);
        wr(24'h200, 2'b10, 32'h0);
        rchk("R8 miss write no effect", 24'h0, 2'b10, ram_exp(0, 2'b10));

        // R3: ROM window in normal map
        for (int a = 0; a < ROMB; a++) begin
            rchk("R3 rom base", 24'(24'h800000 + a), 2'b01, rom_exp(a, 2'b01));
            rchk("R3 rom top", 24'(24'hBFFFC0 + a), 2'b10, rom_exp(a, 2'b10));
        end
        rchk("R3 rom last byte", 24'hBFFFFF, 2'b00, 32'(rom_byte(63)));

        // R5: ROM write in normal map ignored, RAM untouched
        wr(24'h800010, 2'b00, 32'h00);
        rchk("R5 rom write normal", 24'h800010, 2'b00, 32'(rom_byte(16)));
        rchk("R5 ram untouched", 24'h10, 2'b00, 32'(exp_ram[8'h10]));

        // R9: word write samples bit15 (0) not bit7 (1) -> back to boot
        wr(24'hE43000, 2'b01, 32'h0080);
        rchk("R9 word bit15 clear", 24'h0, 2'b00, 32'(rom_byte(0)));
        // R1: overlay write to low address must not reach RAM
        wr(24'h10, 2'b00, 32'h00);
        // R9: long write bit15
        wr(24'hE43000, 2'b10, 32'h0000_8000);
        rchk("R1 overlay write kept off ram", 24'h10, 2'b00, 32'(exp_ram[8'h10]));
        // R9: byte write samples bit7 (0)
        wr(24'hE43000, 2'b00, 32'h0000_FF7F);
        rchk("R9 byte bit7 clear", 24'h11, 2'b00, 32'(rom_byte(17)));
        wr(24'h11, 2'b01, 32'h0);
        // R10: aliased control address in overlay
        wr(24'h643000, 2'b01, 32'h8000);
        rchk("R10 alias ctrl release", 24'h10, 2'b01, ram_exp(8'h10, 2'b01));
        // R9: long write bit15 clear
        wr(24'hE43000, 2'b10, 32'hFFFF_7FFF);
        rchk("R9 long bit15 clear", 24'h20, 2'b10, rom_exp(32, 2'b10));
        wr(24'hE43000, 2'b01, 32'h8000);
        rchk("R9 word release", 24'h20, 2'b10, ram_exp(8'h20, 2'b10));

        // R2: reset mid-run returns to overlay
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rchk("R2 reset returns overlay", 24'h20, 2'b10, rom_exp(32, 2'b10));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule